// File: doc/BRIEF.md
# Dual-Channel Magnitude Threshold Detector

This block watches a 13-bit sample magnitude from each of two converter channels. It raises flags when a magnitude passes programmable limits. Three limits are checked. A coarse upper level is picked by a 3-bit code. A fine upper threshold and a fine lower threshold are each 13 bits wide. A small write-only register file holds the limits and the control settings. Each 13-bit threshold is split across two byte-wide registers.

The comparisons are registered on each valid sample. A control mode then chooses which two of the three results drive each channel's pair of flag pins. The block also produces output-enable signals for the pad drivers that sit outside it.

In separate mode each channel has its own pin pair. In interleaved mode both channels share channel A's pins: channel A is shown on even cycles and channel B on odd cycles. If one channel is powered off, the shared pins keep showing the channel that is still on. The pins are released only when both channels are off or the detector is disabled.

Top module: `mag_thresh_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears: enable 0, mode 0, coarse code 0, both thresholds 0, all registered compare results 0, and the interleave phase 0. After reset both output-enables and all flag pins read 0.
- R2: The fine upper threshold is written in two parts. Address 2 holds bits 7:0, taken from `cfg_wdata[7:0]`. Address 3 holds bits 12:8, taken from `cfg_wdata[4:0]`, and bits 7:5 of that write are ignored. The fine lower threshold uses the same split at addresses 4 and 5. Writes to addresses 6 and 7 change nothing. A write takes effect for samples compared at the following edge.
- R3: The fine-upper result of a channel is 1 only when its magnitude is strictly greater than the fine upper threshold.
- R4: The fine-lower result of a channel is 1 only when its magnitude is strictly less than the fine lower threshold.
- R5: The coarse code N is held in address 1, bits 2:0. The coarse result is 1 when the magnitude is at least 2^(N+5).
- R6: The control register at address 0 holds the enable in bit 0 and the mode in bits 3:1. Each channel's 2-bit pin value `{pin1,pin0}` depends on the mode:
  - mode 0: `{lower, upper}`
  - mode 1: `{upper, coarse}`
  - mode 2: `{lower, coarse}`
  - mode 3: `{0, coarse}`
  - mode 4: `{0, upper}`
  - modes 5 to 7: `00`
- R7: Compare results are registered at a clock edge where `mag_valid` is high. They hold their value at edges where it is low. Flags therefore appear one cycle after a valid magnitude.
- R8: In separate mode (`interleave`=0), `flag_a_oe` = enable AND `chan_a_on`, and `flag_b_oe` = enable AND `chan_b_on`. A flag pair whose output-enable is low reads 00.
- R9: In interleave mode, channel B's pins are always disabled and read 00. Channel A's pins carry channel A's selection while the phase is even and channel B's while it is odd. The phase toggles on every clock after reset, and the first cycle after reset is even.
- R10: In interleave mode with exactly one channel on, the shared pins carry that channel's selection on every cycle. With both channels off, `flag_a_oe` is 0.
- R11: With the enable bit low, both output-enables are 0 and all flag pins read 00, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| mag_valid | input | 1 | Magnitudes valid this cycle |
| mag_a | input | 13 | Channel A magnitude |
| mag_b | input | 13 | Channel B magnitude |
| chan_a_on | input | 1 | Channel A powered and active |
| chan_b_on | input | 1 | Channel B powered and active |
| interleave | input | 1 | Share channel A pins between both channels |
| flag_a | output | 2 | Channel A (or shared) flag pins |
| flag_a_oe | output | 1 | Output-enable for channel A pins |
| flag_b | output | 2 | Channel B flag pins |
| flag_b_oe | output | 1 | Output-enable for channel B pins |

## Verification
On every cycle, the assertions check four things:
- the registered fine results of channel A agree with the previous valid magnitude and the thresholds, and hold when no sample arrives;
- the disable and both-off cases release the pins;
- a disabled pin pair reads zero;
- channel B stays idle while interleaving.

Some behaviours only the bench scenarios can show. These are the split register writes with their ignored bits, the coarse level at each code, the mode table including the unused codes, and the even/odd alternation. The bench's behavioural model checks all of these on every clock.

// File: rtl/mtd_pkg.sv
// Package: shared types, register addresses, mode codes and pin selection
// for the dual-channel magnitude threshold detector.
package mtd_pkg;

    localparam int MAG_W       = 13;
    localparam int COARSE_W    = 3;
    localparam int COARSE_BASE = 5;
    localparam int PIN_W       = 2;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_COARSE = 3'd1;
    localparam logic [2:0] ADDR_UP_LO  = 3'd2;
    localparam logic [2:0] ADDR_UP_HI  = 3'd3;
    localparam logic [2:0] ADDR_LO_LO  = 3'd4;
    localparam logic [2:0] ADDR_LO_HI  = 3'd5;

    typedef enum logic [2:0] {
        MODE_LOW_UP = 3'd0,
        MODE_UP_CRS = 3'd1,
        MODE_LOW_CRS = 3'd2,
        MODE_CRS    = 3'd3,
        MODE_UP     = 3'd4
    } mtd_mode_e;

    typedef struct packed {
        logic coarse;
        logic upper;
        logic lower;
    } mtd_raw_t;

    // Map the three compare results of one channel to its two pins.
    function automatic logic [PIN_W-1:0] mtd_pick(input logic [2:0] mode, input mtd_raw_t r);
        logic [PIN_W-1:0] p;
        case (mode)
            MODE_LOW_UP:  p = {r.lower, r.upper};
            MODE_UP_CRS:  p = {r.upper, r.coarse};
            MODE_LOW_CRS: p = {r.lower, r.coarse};
            MODE_CRS:     p = {1'b0, r.coarse};
            MODE_UP:      p = {1'b0, r.upper};
            default:      p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mtd_regfile.sv
// Module: write-only register file holding control, coarse code and the two
// split 13-bit thresholds. Assumes byte-wide writes; unused addresses are ignored.
module mtd_regfile
    import mtd_pkg::*;
#(
    parameter int THR_W = MAG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [2:0]          addr,
    input  logic [7:0]          wdata,
    output logic                en,
    output logic [2:0]          mode,
    output logic [COARSE_W-1:0] coarse,
    output logic [THR_W-1:0]    up_thr,
    output logic [THR_W-1:0]    low_thr
);
    localparam int HI_W = THR_W - 8;

    logic [7:0]      up_lo_q, low_lo_q;
    logic [HI_W-1:0] up_hi_q, low_hi_q;

    // Register writes, each field at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            mode     <= '0;
            coarse   <= '0;
            up_lo_q  <= '0;
            up_hi_q  <= '0;
            low_lo_q <= '0;
            low_hi_q <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL: begin
                    en   <= wdata[0];
                    mode <= wdata[3:1];
                end
                ADDR_COARSE: coarse   <= wdata[COARSE_W-1:0];
                ADDR_UP_LO:  up_lo_q  <= wdata;
                ADDR_UP_HI:  up_hi_q  <= wdata[HI_W-1:0];
                ADDR_LO_LO:  low_lo_q <= wdata;
                ADDR_LO_HI:  low_hi_q <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Assemble full thresholds from their two parts.
    assign up_thr  = {up_hi_q, up_lo_q};
    assign low_thr = {low_hi_q, low_lo_q};
endmodule

// File: rtl/mtd_chan_cmp.sv
// Module: per-channel comparator bank. Registers coarse, strict-upper and
// strict-lower results on each valid sample and holds them otherwise.
module mtd_chan_cmp
    import mtd_pkg::*;
#(
    parameter int W = MAG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [W-1:0]        mag,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [W-1:0]        up_thr,
    input  logic [W-1:0]        low_thr,
    output mtd_raw_t            raw
);
    localparam int LVL_W = W + 1;

    logic [LVL_W-1:0] crs_level;
    mtd_raw_t         raw_d;

    // Compute the coarse level and the three comparisons.
    always_comb begin
        crs_level    = LVL_W'(1) << ({1'b0, coarse} + 4'(COARSE_BASE));
        raw_d.coarse = {1'b0, mag} >= crs_level;
        raw_d.upper  = mag > up_thr;
        raw_d.lower  = mag < low_thr;
    end

    // Capture results on valid samples only.
    always_ff @(posedge clk) begin
        if (!rst_n)     raw <= '0;
        else if (valid) raw <= raw_d;
    end
endmodule

// File: rtl/mtd_outmux.sv
// Module: pin selection, interleaving and output-enable logic. Assumes channel
// B pins are unused while interleaving; the phase toggles every clock.
module mtd_outmux
    import mtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       mode,
    input  logic             a_on,
    input  logic             b_on,
    input  logic             interleave,
    input  mtd_raw_t         raw_a,
    input  mtd_raw_t         raw_b,
    output logic [PIN_W-1:0] pins_a,
    output logic             oe_a,
    output logic [PIN_W-1:0] pins_b,
    output logic             oe_b
);
    logic             phase;
    logic [PIN_W-1:0] sel_a, sel_b, shared;

    // Even/odd phase counter for interleaving.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Choose pin values and enables from mode, power state and phase.
    always_comb begin
        sel_a = mtd_pick(mode, raw_a);
        sel_b = mtd_pick(mode, raw_b);
        if (a_on && b_on) shared = phase ? sel_b : sel_a;
        else if (b_on)    shared = sel_b;
        else              shared = sel_a;
        if (interleave) begin
            oe_a   = en && (a_on || b_on);
            oe_b   = 1'b0;
            pins_a = oe_a ? shared : '0;
            pins_b = '0;
        end else begin
            oe_a   = en && a_on;
            oe_b   = en && b_on;
            pins_a = oe_a ? sel_a : '0;
            pins_b = oe_b ? sel_b : '0;
        end
    end
endmodule

// File: rtl/mag_thresh_detect.sv
// Module: top of the dual-channel magnitude threshold detector. Holds the
// register file, one comparator bank per channel, and the pin mux.
module mag_thresh_detect
    import mtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             mag_valid,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             chan_a_on,
    input  logic             chan_b_on,
    input  logic             interleave,
    output logic [PIN_W-1:0] flag_a,
    output logic             flag_a_oe,
    output logic [PIN_W-1:0] flag_b,
    output logic             flag_b_oe
);
    localparam int NCH = 2;

    logic                cfg_en;
    logic [2:0]          cfg_mode;
    logic [COARSE_W-1:0] coarse_code;
    logic [MAG_W-1:0]    up_thr, low_thr;
    logic [MAG_W-1:0]    mag_arr [NCH];
    mtd_raw_t            raw_arr [NCH];

    assign mag_arr[0] = mag_a;
    assign mag_arr[1] = mag_b;

    mtd_regfile #(.THR_W(MAG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .en(cfg_en), .mode(cfg_mode), .coarse(coarse_code),
        .up_thr(up_thr), .low_thr(low_thr)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        mtd_chan_cmp #(.W(MAG_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .valid(mag_valid), .mag(mag_arr[ch]),
            .coarse(coarse_code), .up_thr(up_thr), .low_thr(low_thr),
            .raw(raw_arr[ch])
        );
    end

    mtd_outmux u_mux (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .mode(cfg_mode),
        .a_on(chan_a_on), .b_on(chan_b_on), .interleave(interleave),
        .raw_a(raw_arr[0]), .raw_b(raw_arr[1]),
        .pins_a(flag_a), .oe_a(flag_a_oe), .pins_b(flag_b), .oe_b(flag_b_oe)
    );
endmodule

// File: rtl/mtd_checker.sv
// Module: property checker for the threshold detector, bound into the top.
module mtd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mag_valid,
    input logic [12:0] mag_a,
    input logic        chan_a_on,
    input logic        chan_b_on,
    input logic        interleave,
    input logic        cfg_en,
    input logic [12:0] up_thr,
    input logic [12:0] low_thr,
    input logic        raw_up,
    input logic        raw_low,
    input logic [1:0]  flag_a,
    input logic        flag_a_oe,
    input logic [1:0]  flag_b,
    input logic        flag_b_oe
);
    a_r3_upper_strict: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mag_valid)) |-> (raw_up == ($past(mag_a) > $past(up_thr))));

    a_r4_lower_strict: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mag_valid)) |-> (raw_low == ($past(mag_a) < $past(low_thr))));

    a_r7_hold_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mag_valid)) |-> ($stable(raw_up) && $stable(raw_low)));

    a_r11_disabled_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (!flag_a_oe && !flag_b_oe));

    a_r10_both_off: assert property (@(posedge clk) disable iff (!rst_n)
        (interleave && !chan_a_on && !chan_b_on) |-> !flag_a_oe);

    a_r9_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
        interleave |-> (!flag_b_oe && flag_b == 2'b00));

    a_r8_zero_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_a_oe |-> flag_a == 2'b00) and (!flag_b_oe |-> flag_b == 2'b00));
endmodule

bind mag_thresh_detect mtd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mag_valid(mag_valid), .mag_a(mag_a),
    .chan_a_on(chan_a_on), .chan_b_on(chan_b_on), .interleave(interleave),
    .cfg_en(cfg_en), .up_thr(up_thr), .low_thr(low_thr),
    .raw_up(raw_arr[0].upper), .raw_low(raw_arr[0].lower),
    .flag_a(flag_a), .flag_a_oe(flag_a_oe), .flag_b(flag_b), .flag_b_oe(flag_b_oe)
);

// File: tb/mag_thresh_detect_test.sv
`timescale 1ns/1ps
module mag_thresh_detect_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        mag_valid;
    logic [12:0] mag_a, mag_b;
    logic        chan_a_on, chan_b_on, interleave;
    logic [1:0]  flag_a, flag_b;
    logic        flag_a_oe, flag_b_oe;

    int total = 0;
    int bad   = 0;
    string req_tag = "R1";

    // behavioural model state
    int m_en, m_mode, m_crs, m_up, m_low, m_phase;
    int m_c[2], m_u[2], m_l[2];

    always #2.5 clk = ~clk;

    mag_thresh_detect uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mag_valid(mag_valid), .mag_a(mag_a), .mag_b(mag_b),
        .chan_a_on(chan_a_on), .chan_b_on(chan_b_on), .interleave(interleave),
        .flag_a(flag_a), .flag_a_oe(flag_a_oe), .flag_b(flag_b), .flag_b_oe(flag_b_oe)
    );

    // model update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_crs = 0; m_up = 0; m_low = 0; m_phase = 0;
            for (int i = 0; i < 2; i++) begin m_c[i] = 0; m_u[i] = 0; m_l[i] = 0; end
        end else begin
            if (mag_valid) begin
                for (int i = 0; i < 2; i++) begin
                    int m;
                    m = (i == 0) ? int'(mag_a) : int'(mag_b);
                    m_c[i] = (m >= (1 << (m_crs + 5))) ? 1 : 0;
                    m_u[i] = (m > m_up) ? 1 : 0;
                    m_l[i] = (m < m_low) ? 1 : 0;
                end
            end
            if (cfg_we) begin
                int d;
                d = int'(cfg_wdata);
                case (cfg_addr)
                    3'd0: begin m_en = d % 2; m_mode = (d / 2) % 8; end
                    3'd1: m_crs = d % 8;
                    3'd2: m_up  = (m_up  / 256) * 256 + d;
                    3'd3: m_up  = (m_up  % 256) + (d % 32) * 256;
                    3'd4: m_low = (m_low / 256) * 256 + d;
                    3'd5: m_low = (m_low % 256) + (d % 32) * 256;
                    default: ;
                endcase
            end
            m_phase = 1 - m_phase;
        end
    end

    function automatic int pick(int mode, int c, int u, int l);
        case (mode)
            0: return l * 2 + u;
            1: return u * 2 + c;
            2: return l * 2 + c;
            3: return c;
            4: return u;
            default: return 0;
        endcase
    endfunction

    task automatic check_pins();
        int ea, eb, eoa, eob, sa, sb, src;
        sa = pick(m_mode, m_c[0], m_u[0], m_l[0]);
        sb = pick(m_mode, m_c[1], m_u[1], m_l[1]);
        if (interleave) begin
            eoa = (m_en == 1 && (chan_a_on || chan_b_on)) ? 1 : 0;
            eob = 0;
            if (chan_a_on && chan_b_on) src = m_phase ? sb : sa;
            else if (chan_b_on)         src = sb;
            else                        src = sa;
            ea = eoa ? src : 0;
            eb = 0;
        end else begin
            eoa = (m_en == 1 && chan_a_on) ? 1 : 0;
            eob = (m_en == 1 && chan_b_on) ? 1 : 0;
            ea = eoa ? sa : 0;
            eb = eob ? sb : 0;
        end
        total++;
        if (int'(flag_a) != ea || int'(flag_b) != eb ||
            int'(flag_a_oe) != eoa || int'(flag_b_oe) != eob) begin
            bad++;
            $display("FAIL %s: a=%0d oe_a=%0d b=%0d oe_b=%0d expected a=%0d oe_a=%0d b=%0d oe_b=%0d",
                     req_tag, flag_a, flag_a_oe, flag_b, flag_b_oe, ea, eoa, eb, eob);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_pins();
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic sample(input int a, input int b);
        mag_valid = 1'b1; mag_a = 13'(a); mag_b = 13'(b);
        step();
        step();
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            mag_valid = 1'($urandom);
            mag_a = 13'($urandom); mag_b = 13'($urandom >> 3);
            step();
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        mag_valid = 1'b1; mag_a = 13'h1FFF; mag_b = 13'h1FFF;
        chan_a_on = 1'b1; chan_b_on = 1'b1; interleave = 1'b0;
        req_tag = "R1";
        repeat (5) step();
        rst_n = 1'b1;
        mag_valid = 1'b0;
        step();  // R1: outputs released after reset

        // R2: split thresholds, upper bits of high byte ignored
        req_tag = "R2";
        wr(0, 8'b0000_0001);           // enable, mode 0
        wr(2, 8'h34); wr(3, 8'hE2);    // upper = 0x234
        wr(4, 8'h10); wr(5, 8'hE0);    // lower = 0x010
        wr(6, 8'hFF); wr(7, 8'hFF);    // no effect
        // R3: strict upper boundary
        req_tag = "R3";
        sample(13'h234, 13'h235); sample(13'h235, 13'h233); sample(13'h1FFF, 0);
        // R4: strict lower boundary
        req_tag = "R4";
        sample(13'h010, 13'h00F); sample(13'h00F, 13'h011); sample(0, 13'h010);

        // R5: coarse level for every code
        req_tag = "R5";
        wr(0, 8'b0000_0011);           // mode 1
        for (int n = 0; n < 8; n++) begin
            wr(1, n);
            sample((1 << (n + 5)) - 1, 1 << (n + 5));
            sample(1 << (n + 5), (1 << (n + 5)) - 1);
        end

        // R6: every mode code including unused ones
        req_tag = "R6";
        for (int md = 0; md < 8; md++) begin
            wr(0, md * 2 + 1);
            wr(1, $urandom % 8);
            rand_run(25);
        end

        // R7: results hold without valid samples
        req_tag = "R7";
        wr(0, 8'b0000_0001);
        sample(13'h1FFF, 0);
        mag_valid = 1'b0;
        for (int i = 0; i < 10; i++) begin
            mag_a = 13'($urandom); mag_b = 13'($urandom); step();
        end

        // R8: separate mode with each power combination
        req_tag = "R8";
        for (int pc = 0; pc < 4; pc++) begin
            chan_a_on = pc[0]; chan_b_on = pc[1];
            rand_run(20);
        end

        // R9 / R10: interleaving with each power combination
        interleave = 1'b1;
        for (int pc = 3; pc >= 0; pc--) begin
            req_tag = (pc == 3) ? "R9" : "R10";
            chan_a_on = pc[0]; chan_b_on = pc[1];
            rand_run(30);
        end

        // R11: disabled detector releases every pin
        req_tag = "R11";
        wr(0, 8'b0000_0010);
        for (int pc = 0; pc < 8; pc++) begin
            interleave = pc[2]; chan_a_on = pc[0]; chan_b_on = pc[1];
            rand_run(10);
        end

        // mixed random traffic, including writes
        req_tag = "R6";
        for (int i = 0; i < 1500; i++) begin
            cfg_we = ($urandom % 8) == 0;
            cfg_addr = 3'($urandom);
            cfg_wdata = 8'($urandom);
            if (cfg_we && cfg_addr == 3'd0) cfg_wdata[0] = 1'b1;
            mag_valid = 1'($urandom);
            mag_a = 13'($urandom); mag_b = 13'($urandom);
            chan_a_on = 1'($urandom); chan_b_on = 1'($urandom);
            interleave = 1'($urandom);
            step();
        end
        cfg_we = 1'b0;

        // R1: reset again mid-run
        req_tag = "R1";
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule